// File: doc/BRIEF.md
# Post-Mortem Trigger with Automatic Re-Arm

This block sits between the two beam-permit flags of a two-ring collider and the event generator of the central timing system. Each flag is high while its ring may hold beam. When a flag falls, the block always asks for a beam-dump event for that ring. It also asks for a post-mortem event, provided that ring's trigger is armed and the machine mode does not inhibit post-mortem recording. The post-mortem request waits for the next strobe of a 1 kHz tick, which gives a delay of one tick.

Operators and sequencers send per-ring disarm and arm commands. A disarm command also starts a countdown in tick strobes. When the countdown ends, the ring is re-armed, so the next flag drop triggers again without any further command. When both rings produce requests at the same strobe, the two requests leave as separate pulses in consecutive clocks, ring one first.

All outputs are single-cycle request pulses. There is no valid/ready handshake and no back-pressure: the consumer must accept a pulse in any cycle. Control inputs are plain levels or one-cycle pulses.

Top module: `pm_trig_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `pm_req` and `dump_req` are low, and both rings leave reset armed.
- R2: A falling edge on `beam_permit[r]` passes through a two-stage synchronizer. It produces exactly one `dump_req[r]` pulse, high in the third clock after the input changes. A rising edge produces nothing.
- R3: The dump pulse of R2 is issued whatever the arm state of the ring and the level of `pm_inhibit`.
- R4: When ring r is armed and not inhibited at the cycle its falling edge is detected, one `pm_req` pulse follows. It is high in the clock after the first `slow_tick` strobe that comes later than that detection cycle. `pm_ring` is 0 for ring one and 1 for ring two.
- R5: A falling edge on a disarmed ring produces no `pm_req` pulse.
- R6: A `pm_disable[r]` pulse disarms ring r from the next clock. A `pm_enable[r]` pulse arms it. When both pulses arrive in the same cycle, disarm wins.
- R7: A disarm starts a countdown of `REARM_TICKS` (default 2) `slow_tick` strobes, counted from strobes later than the command cycle. The ring re-arms after the last strobe of the countdown. A new disarm restarts the countdown, and an arm command cancels it.
- R8: `pm_inhibit` is sampled in the cycle the falling edge is detected. If it is high then, no `pm_req` is issued for that edge.
- R9: `pm_req` never carries two rings in one cycle. When both rings are released by the same strobe, ring one pulses first and ring two pulses in the next clock. Several drops on one ring within one tick window give a single pulse.
- R10: Issuing a post-mortem request does not disarm the ring. A later drop on the same ring triggers again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe at 1 kHz |
| beam_permit | input | 2 | Asynchronous permit flags, bit 0 ring one, bit 1 ring two |
| pm_disable | input | 2 | Per-ring disarm command pulses |
| pm_enable | input | 2 | Per-ring arm command pulses |
| pm_inhibit | input | 1 | Machine mode blocks post-mortem requests |
| pm_req | output | 1 | Post-mortem event request pulse |
| pm_ring | output | 1 | Ring of the current `pm_req` (0 ring one, 1 ring two) |
| dump_req | output | 2 | Per-ring beam-dump event request pulses |

## Verification
Two collisions can occur in one cycle. The first is both rings being released toward `pm_req` by the same tick strobe. The bench provokes it by dropping both flags in the same cycle. It then judges that ring one's pulse sits in the clock after the strobe and ring two's pulse in the clock after that, with one pulse per ring. The second is a disarm and an arm command arriving together. The bench checks that the next drop yields a dump and no post-mortem request, and that a countdown restarted by a second disarm re-arms only after a full count from the later command.

// File: rtl/pm_trig_pkg.sv
package pm_trig_pkg;
  localparam int NRING  = 2;
  localparam int RING_W = (NRING > 1) ? $clog2(NRING) : 1;
  typedef logic [NRING-1:0]  ring_mask_t;
  typedef logic [RING_W-1:0] ring_idx_t;
endpackage

// File: rtl/pm_flag_edge.sv
module pm_flag_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic permit_async,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], permit_async};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/pm_arm_ctrl.sv
module pm_arm_ctrl #(
  parameter int REARM_TICKS  = 2,
  parameter bit ARM_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dis_cmd,
  input  logic en_cmd,
  output logic armed
);
  localparam int CNT_W = $clog2(REARM_TICKS + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= ARM_AT_RESET;
      remain <= '0;
    end else if (dis_cmd) begin
      armed  <= 1'b0;
      remain <= CNT_W'(REARM_TICKS);
    end else if (en_cmd) begin
      armed  <= 1'b1;
      remain <= '0;
    end else if (tick && remain != '0) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/pm_req_serializer.sv
module pm_req_serializer
  import pm_trig_pkg::*;
#(
  parameter int N = NRING
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N-1:0]     fire,
  output logic             req,
  output logic [RING_W-1:0] req_ring
);
  logic [N-1:0]      pending;
  logic [N-1:0]      queued;
  logic [N-1:0]      cand;
  logic [N-1:0]      grant;
  logic [RING_W-1:0] sel;
  logic              any;

  assign cand = queued | (tick ? pending : '0);

  always_comb begin
    sel   = '0;
    any   = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !any) begin
        sel      = RING_W'(i);
        any      = 1'b1;
        grant[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= '0;
      queued   <= '0;
      req      <= 1'b0;
      req_ring <= '0;
    end else begin
      pending  <= tick ? fire : (pending | fire);
      queued   <= cand & ~grant;
      req      <= any;
      req_ring <= sel;
    end
  end
endmodule

// File: rtl/pm_trig_top.sv
module pm_trig_top
  import pm_trig_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int REARM_TICKS  = 2,
  parameter bit ARM_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [NRING-1:0]  beam_permit,
  input  logic [NRING-1:0]  pm_disable,
  input  logic [NRING-1:0]  pm_enable,
  input  logic              pm_inhibit,
  output logic              pm_req,
  output logic [RING_W-1:0] pm_ring,
  output logic [NRING-1:0]  dump_req
);
  ring_mask_t fall_vec;
  ring_mask_t armed_vec;
  ring_mask_t fire_vec;

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    pm_flag_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk          (clk),
      .rst_n        (rst_n),
      .permit_async (beam_permit[r]),
      .fall         (fall_vec[r])
    );

    pm_arm_ctrl #(.REARM_TICKS(REARM_TICKS), .ARM_AT_RESET(ARM_AT_RESET)) i_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (slow_tick),
      .dis_cmd (pm_disable[r]),
      .en_cmd  (pm_enable[r]),
      .armed   (armed_vec[r])
    );
  end

  assign fire_vec = fall_vec & armed_vec & {NRING{~pm_inhibit}};

  always_ff @(posedge clk) begin
    if (!rst_n) dump_req <= '0;
    else        dump_req <= fall_vec;
  end

  pm_req_serializer #(.N(NRING)) i_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (slow_tick),
    .fire     (fire_vec),
    .req      (pm_req),
    .req_ring (pm_ring)
  );
endmodule

// File: rtl/pm_trig_checker.sv
module pm_trig_checker
  import pm_trig_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              slow_tick,
  input logic [NRING-1:0]  pm_disable,
  input logic [NRING-1:0]  pm_enable,
  input logic              pm_req,
  input logic [RING_W-1:0] pm_ring,
  input logic [NRING-1:0]  dump_req,
  input logic [NRING-1:0]  armed
);
  p_pm_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req |-> ($past(slow_tick) || $past(pm_req)));

  p_distinct_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req && $past(pm_req)) |-> (pm_ring != $past(pm_ring)));

  for (genvar r = 0; r < NRING; r++) begin : g_chk
    p_dump_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dump_req[r] |=> !dump_req[r]);

    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pm_disable[r] |=> !armed[r]);

    p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_enable[r] && !pm_disable[r]) |=> armed[r]);

    p_rearm_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed[r]) |-> ($past(pm_enable[r]) || $past(slow_tick)));
  end
endmodule

bind pm_trig_top pm_trig_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_tick  (slow_tick),
  .pm_disable (pm_disable),
  .pm_enable  (pm_enable),
  .pm_req     (pm_req),
  .pm_ring    (pm_ring),
  .dump_req   (dump_req),
  .armed      (armed_vec)
);

// File: tb/test_pm_trig_top.sv
`timescale 1ns/1ps
module test_pm_trig_top;
  localparam int TICK_CYC = 40;
  localparam int REARM    = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic [1:0] beam_permit = 2'b11;
  logic [1:0] pm_disable = 2'b00;
  logic [1:0] pm_enable = 2'b00;
  logic       pm_inhibit = 1'b0;
  logic       pm_req;
  logic [0:0] pm_ring;
  logic [1:0] dump_req;

  pm_trig_top #(.REARM_TICKS(REARM)) i_pm_trig_top (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .beam_permit(beam_permit),
    .pm_disable(pm_disable), .pm_enable(pm_enable), .pm_inhibit(pm_inhibit),
    .pm_req(pm_req), .pm_ring(pm_ring), .dump_req(dump_req)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int pm_cnt[2];
  int dump_cnt[2];
  int last_pm[2];
  int last_dump[2];
  bit mdl_en[2];
  int tk_since[2];

  always @(negedge clk) begin
    if (rst_n) begin
      if (pm_req) begin
        pm_cnt[pm_ring]++;
        last_pm[pm_ring] = cyc;
      end
      for (int r = 0; r < 2; r++)
        if (dump_req[r]) begin
          dump_cnt[r]++;
          last_dump[r] = cyc;
        end
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
    finish_up();
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit armed_mdl(int r);
    return mdl_en[r] || (tk_since[r] >= REARM);
  endfunction

  function automatic bit exp_pm(int r, logic [1:0] mask, bit inh);
    return mask[r] && armed_mdl(r) && !inh;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
    slow_tick = (cyc % TICK_CYC == 0);
    if (slow_tick)
      for (int r = 0; r < 2; r++) if (tk_since[r] < 1000) tk_since[r]++;
  endtask

  task automatic wait_phase(int p);
    while (cyc % TICK_CYC != p) step();
  endtask

  task automatic send_cmd(logic [1:0] dis, logic [1:0] en);
    wait_phase(10);
    pm_disable = dis;
    pm_enable  = en;
    for (int r = 0; r < 2; r++) begin
      if (dis[r]) begin
        mdl_en[r] = 1'b0;
        tk_since[r] = 0;
      end else if (en[r]) begin
        mdl_en[r] = 1'b1;
      end
    end
    step();
    pm_disable = '0;
    pm_enable  = '0;
  endtask

  task automatic do_drop(logic [1:0] mask, bit inh);
    int d;
    int p0[2];
    int d0[2];
    bit e[2];
    string tag;
    wait_phase(20);
    pm_inhibit = inh;
    for (int r = 0; r < 2; r++) begin
      p0[r] = pm_cnt[r];
      d0[r] = dump_cnt[r];
      e[r]  = exp_pm(r, mask, inh);
    end
    d = cyc;
    beam_permit = ~mask;
    step();
    while (cyc % TICK_CYC != 5) step();
    for (int r = 0; r < 2; r++) begin
      tag = (inh || !armed_mdl(r)) ? "R3" : "R2";
      check(dump_cnt[r] - d0[r] == int'(mask[r]), tag, dump_cnt[r] - d0[r], int'(mask[r]));
      if (mask[r]) check(last_dump[r] == d + 3, "R2", last_dump[r] - d, 3);
      tag = inh ? "R8" : (e[r] ? "R4" : "R5");
      check(pm_cnt[r] - p0[r] == int'(e[r]), tag, pm_cnt[r] - p0[r], int'(e[r]));
      if (e[r]) begin
        int ph;
        ph = (r == 1 && e[0]) ? 2 : 1;
        check(last_pm[r] % TICK_CYC == ph, (ph == 2) ? "R9" : "R4",
              last_pm[r] % TICK_CYC, ph);
      end
    end
    beam_permit = 2'b11;
    pm_inhibit  = 1'b0;
    repeat (5) step();
  endtask

  initial begin
    for (int r = 0; r < 2; r++) begin
      pm_cnt[r] = 0; dump_cnt[r] = 0; last_pm[r] = 0; last_dump[r] = 0;
      mdl_en[r] = 1'b1; tk_since[r] = 1000;
    end
    void'($urandom(32'd1947));
    repeat (4) step();
    check(pm_req == 1'b0 && dump_req == 2'b00, "R1", {pm_req, dump_req}, 0);
    rst_n = 1'b1;
    step();
    check(pm_req == 1'b0 && dump_req == 2'b00, "R1", {pm_req, dump_req}, 0);

    do_drop(2'b01, 1'b0);          // R1 armed at reset, R4 ring one
    do_drop(2'b01, 1'b0);          // R10 still armed after firing
    do_drop(2'b10, 1'b0);          // R4 ring two alone
    do_drop(2'b11, 1'b0);          // R9 both rings, same strobe
    do_drop(2'b11, 1'b1);          // R8 inhibit, R3 dumps still out

    send_cmd(2'b01, 2'b00);        // R6 disarm ring one
    do_drop(2'b01, 1'b0);          // R5 no pm, zero strobes elapsed
    do_drop(2'b01, 1'b0);          // R7 one strobe elapsed, still disarmed
    do_drop(2'b01, 1'b0);          // R7 two strobes, re-armed

    send_cmd(2'b10, 2'b00);        // R7 restart of countdown
    do_drop(2'b10, 1'b0);
    send_cmd(2'b10, 2'b00);
    do_drop(2'b10, 1'b0);
    do_drop(2'b10, 1'b0);
    do_drop(2'b10, 1'b0);

    send_cmd(2'b01, 2'b00);        // R7 arm command cancels countdown
    send_cmd(2'b00, 2'b01);
    do_drop(2'b01, 1'b0);
    send_cmd(2'b11, 2'b11);        // R6 disarm wins over same-cycle arm
    do_drop(2'b11, 1'b0);
    check(!armed_mdl(0) && !armed_mdl(1), "R6", armed_mdl(0), 0);

    for (int it = 0; it < 40; it++) begin
      logic [1:0] dis;
      logic [1:0] en;
      logic [1:0] mask;
      int wins;
      dis  = 2'($urandom_range(0, 3));
      en   = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) dis = '0;
      send_cmd(dis, en);
      wins = $urandom_range(0, 3);
      for (int w = 0; w < wins; w++) begin
        step();
        wait_phase(10);
      end
      mask = 2'($urandom_range(1, 3));
      do_drop(mask, ($urandom_range(0, 3) == 0));
    end

    finish_up();
  end
endmodule